// File: doc/BRIEF.md
# Configuration Clock Length Counter with Startup Sequencer

This block follows the serial loading of a programmable device's configuration and decides when loading is complete. It runs on the configuration clock. From the first clock after a program/reset it counts every clock, whether the data bit on that clock is meaningful or a stray bit ahead of the bitstream. While this happens, a header field carrying the expected total clock count (the length value) is shifted in serially, most significant bit first. The frame loader separately reports when the internal configuration memory has been filled.

Completion needs the memory to be full and the clock count to equal the length value exactly. A count that has already run past the length value gives no completion. The counter then has to wrap through its all-ones value back to zero and climb to the length value again. Once completion is detected, a three-phase startup sequence raises the done indication, then enables the user outputs, then releases the global set/reset. After that the block stays in its configured state.

When frame checking is enabled, a frame-error strobe seen during loading sets a sticky error. The error pulls the open-drain error line low and blocks completion until the next program/reset.

Top module: `cfg_startup_top`

## Requirements
- R1: A clock edge with `prog_n` low clears the clock counter, the length value, the length-loaded status, the startup phase and the error flag. After that edge `done` is 0, `outs_active` is 0, `gsr_hold` is 1 and `init_pull_low` is 0.
- R2: The clock counter is `CNT_W` bits wide. While the block is loading, it increments by one on every clock edge with `prog_n` high, starting with the first such edge. Edges that carry stray bits ahead of the length field are counted too.
- R3: On each edge with `len_vld` high, `din` is shifted into the length value, most significant bit first. After exactly `CNT_W` such edges the value is complete. Further `len_vld` edges leave it unchanged.
- R4: The block leaves the loading state on an edge where four conditions hold before that edge: the length value is complete, `mem_full` is 1, the count equals the length value, and no error is set or being set. After that edge `done` is 1. With clocks numbered 1, 2, ... after the reset edge, the count seen at edge k is k-1, so completion happens at the first edge k with k-1 equal to the length value.
- R5: The comparison is modulo 2^`CNT_W`. If the count passes the length value before the other conditions hold, completion waits until the count wraps from 2^`CNT_W`-1 to 0 and reaches the length value again.
- R6: If `done` rises at edge k, `outs_active` rises at edge k+1 and `gsr_hold` falls at edge k+2.
- R7: After the third phase the block stays configured. Later clocks and changes on `mem_full`, `len_vld`, `din`, `crc_en` or `frame_err` do not change `done`, `outs_active`, `gsr_hold` or `init_pull_low`.
- R8: An edge during loading with both `crc_en` and `frame_err` high sets the error. `init_pull_low` is 1 after that edge and stays 1 until a `prog_n` low edge.
- R9: While the error is set, `done` stays 0, even when the count matches the length value and `mem_full` is 1.
- R10: With `crc_en` low, `frame_err` has no effect. `init_pull_low` stays 0 and completion happens at the edge given by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| prog_n | input | 1 | Synchronous active-low program/reset |
| din | input | 1 | Serial configuration data bit |
| len_vld | input | 1 | Current `din` bit belongs to the length field |
| mem_full | input | 1 | Configuration memory full, from the frame loader |
| crc_en | input | 1 | Frame error checking enabled (0 = disabled, the default) |
| frame_err | input | 1 | Frame error strobe from the checker |
| done | output | 1 | Configuration complete, active from startup phase 0 |
| outs_active | output | 1 | User outputs enabled, from startup phase 1 |
| gsr_hold | output | 1 | Global set/reset held, released in startup phase 2 |
| init_pull_low | output | 1 | Drive the open-drain error line low |

## Verification
The bench builds the block with `CNT_W = 6`, so the counter wraps every 64 clocks. At that width a run that overshoots the length value, or whose length value is shorter than the header load time, reaches completion again after the wrap within a short run. The default 24-bit width would need about sixteen million clocks for the same case. At 6 bits the bench also reaches the all-ones length value and exact matches on the very edge where the memory becomes full, and it still shifts the length field serially as in the wide build.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

    typedef enum logic [2:0] {
        PH_LOAD  = 3'd0,
        PH_0     = 3'd1,
        PH_1     = 3'd2,
        PH_2     = 3'd3,
        PH_FINAL = 3'd4
    } phase_e;

endpackage

// File: rtl/cfg_len_shift.sv
module cfg_len_shift #(
    parameter int LEN_W = 24
) (
    input  logic             cclk,
    input  logic             prog_n,
    input  logic             din,
    input  logic             shift_en,
    output logic [LEN_W-1:0] len_val,
    output logic             len_ready
);
    localparam int BC_W = $clog2(LEN_W + 1);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [BC_W-1:0]  nbits;
        logic             ready;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!prog_n) begin
            sh_d = '0;
        end else if (shift_en && !sh_q.ready) begin
            sh_d.len   = {sh_q.len[LEN_W-2:0], din};
            sh_d.nbits = sh_q.nbits + BC_W'(1);
            if (sh_q.nbits == BC_W'(LEN_W - 1)) begin
                sh_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge cclk) begin
        sh_q <= sh_d;
    end

    assign len_val   = sh_q.len;
    assign len_ready = sh_q.ready;

    // R3
    len_hold_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        sh_q.ready |=> (sh_q.ready && $stable(sh_q.len)));

endmodule

// File: rtl/cfg_clk_count.sv
module cfg_clk_count #(
    parameter int CNT_W = 24
) (
    input  logic             cclk,
    input  logic             prog_n,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cn_d, cn_q;

    always_comb begin
        cn_d = cn_q;
        if (!prog_n) begin
            cn_d.cnt = '0;
        end else if (run) begin
            cn_d.cnt = cn_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge cclk) begin
        cn_q <= cn_d;
    end

    assign count = cn_q.cnt;

    // R2
    cnt_step_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        run |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_startup_pkg::*;
(
    input  logic cclk,
    input  logic prog_n,
    input  logic hit,
    input  logic crc_en,
    input  logic frame_err,
    output logic running,
    output logic done,
    output logic outs_active,
    output logic gsr_hold,
    output logic init_pull_low
);
    typedef struct packed {
        phase_e phase;
        logic   err;
    } seq_t;

    seq_t sq_d, sq_q;
    logic err_new;

    always_comb begin
        sq_d    = sq_q;
        err_new = crc_en && frame_err && (sq_q.phase == PH_LOAD);
        if (!prog_n) begin
            sq_d.phase = PH_LOAD;
            sq_d.err   = 1'b0;
        end else begin
            sq_d.err = sq_q.err || err_new;
            case (sq_q.phase)
                PH_LOAD:  if (hit && !sq_d.err) sq_d.phase = PH_0;
                PH_0:     sq_d.phase = PH_1;
                PH_1:     sq_d.phase = PH_2;
                PH_2:     sq_d.phase = PH_FINAL;
                PH_FINAL: sq_d.phase = PH_FINAL;
                default:  sq_d.phase = PH_LOAD;
            endcase
        end
    end

    always_ff @(posedge cclk) begin
        sq_q <= sq_d;
    end

    assign running       = (sq_q.phase == PH_LOAD);
    assign done          = (sq_q.phase != PH_LOAD);
    assign outs_active   = (sq_q.phase == PH_1) || (sq_q.phase == PH_2) ||
                           (sq_q.phase == PH_FINAL);
    assign gsr_hold      = (sq_q.phase == PH_LOAD) || (sq_q.phase == PH_0) ||
                           (sq_q.phase == PH_1);
    assign init_pull_low = sq_q.err;

    // R1
    reset_clear_chk: assert property (@(posedge cclk)
        !prog_n |=> (!done && !outs_active && gsr_hold && !init_pull_low));

    // R6
    outs_after_done_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        $rose(outs_active) |-> $past(done));

    // R6
    gsr_after_outs_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        $fell(gsr_hold) |-> $past(outs_active));

    // R7
    final_hold_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        (sq_q.phase == PH_FINAL) |=> (sq_q.phase == PH_FINAL));

    // R8
    err_sticky_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        sq_q.err |=> sq_q.err);

    // R9
    err_blocks_done_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        sq_q.err |-> !done);

endmodule

// File: rtl/cfg_startup_top.sv
module cfg_startup_top #(
    parameter int CNT_W = 24
) (
    input  logic cclk,
    input  logic prog_n,
    input  logic din,
    input  logic len_vld,
    input  logic mem_full,
    input  logic crc_en,
    input  logic frame_err,
    output logic done,
    output logic outs_active,
    output logic gsr_hold,
    output logic init_pull_low
);
    logic [CNT_W-1:0] len_val;
    logic [CNT_W-1:0] count;
    logic             len_ready;
    logic             running;
    logic             hit;

    cfg_len_shift #(.LEN_W(CNT_W)) u_len (
        .cclk      (cclk),
        .prog_n    (prog_n),
        .din       (din),
        .shift_en  (len_vld),
        .len_val   (len_val),
        .len_ready (len_ready)
    );

    cfg_clk_count #(.CNT_W(CNT_W)) u_cnt (
        .cclk   (cclk),
        .prog_n (prog_n),
        .run    (running),
        .count  (count)
    );

    assign hit = len_ready && mem_full && (count == len_val);

    cfg_startup_seq u_seq (
        .cclk          (cclk),
        .prog_n        (prog_n),
        .hit           (hit),
        .crc_en        (crc_en),
        .frame_err     (frame_err),
        .running       (running),
        .done          (done),
        .outs_active   (outs_active),
        .gsr_hold      (gsr_hold),
        .init_pull_low (init_pull_low)
    );

    // R4
    done_match_chk: assert property (@(posedge cclk) disable iff (!prog_n)
        $rose(done) |-> $past(mem_full && len_ready && (count == len_val)));

endmodule

// File: tb/cfg_startup_top_bench.sv
module cfg_startup_top_bench;
    localparam int W = 6;

    logic clk = 1'b0;
    logic prog_n = 1'b0;
    logic din = 1'b0, len_vld = 1'b0, mem_full = 1'b0;
    logic crc_en = 1'b0, frame_err = 1'b0;
    logic done, outs_active, gsr_hold, init_pull_low;

    int total = 0;
    int bad = 0;

    cfg_startup_top #(.CNT_W(W)) u_cfg_startup_top (
        .cclk(clk), .prog_n(prog_n), .din(din), .len_vld(len_vld),
        .mem_full(mem_full), .crc_en(crc_en), .frame_err(frame_err),
        .done(done), .outs_active(outs_active), .gsr_hold(gsr_hold),
        .init_pull_low(init_pull_low)
    );

    always #5 clk = ~clk;

    // len, stray lead bits, edge after which mem_full rises,
    // crc enable, edge carrying frame_err (0 = none), expected done edge (0 = never)
    typedef struct packed {
        logic [7:0] len;
        logic [7:0] lead;
        logic [7:0] full_at;
        logic [7:0] crc;
        logic [7:0] err_at;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd20, 8'd0, 8'd5,  8'd0, 8'd0,  8'd21},  // R4 plain match
        '{8'd20, 8'd3, 8'd30, 8'd0, 8'd0,  8'd85},  // R5 overshoot, wrap
        '{8'd8,  8'd0, 8'd0,  8'd0, 8'd0,  8'd9},   // R3 first edge after load
        '{8'd3,  8'd0, 8'd0,  8'd0, 8'd0,  8'd68},  // R5 length below load time
        '{8'd63, 8'd2, 8'd10, 8'd0, 8'd0,  8'd64},  // R2 all-ones length
        '{8'd40, 8'd5, 8'd40, 8'd0, 8'd0,  8'd41},  // R4 full on match edge
        '{8'd20, 8'd0, 8'd5,  8'd1, 8'd10, 8'd0},   // R9 error blocks done
        '{8'd20, 8'd0, 8'd5,  8'd0, 8'd10, 8'd21}   // R10 error ignored
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        prog_n = 1'b0; din = 1'b0; len_vld = 1'b0; mem_full = 1'b0;
        crc_en = 1'b0; frame_err = 1'b0;
        step();
        prog_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int limit;
        int nd = 0, no = 0, ng = 0, ni = 0;
        int fd = -1, fo = -1, fg = -1, fi = -1;
        do_reset();
        crc_en = v.crc[0];
        limit = (v.exp == 0) ? 100 : int'(v.exp) + 6;
        for (int e = 1; e <= limit; e++) begin
            if (e <= int'(v.lead)) begin
                len_vld = 1'b0; din = e[0];
            end else if (e <= int'(v.lead) + W) begin
                len_vld = 1'b1; din = v.len[W - (e - int'(v.lead))];
            end else if (e <= int'(v.lead) + W + 3) begin
                len_vld = 1'b1; din = 1'b1;      // extra bits, R3 ignores them
            end else begin
                len_vld = 1'b0; din = 1'b0;
            end
            mem_full  = (e >= int'(v.full_at) + 1);
            frame_err = (v.err_at != 0) && (e == int'(v.err_at));
            step();
            if (done != ((v.exp != 0) && e >= int'(v.exp))) begin nd++; if (fd < 0) fd = e; end
            if (outs_active != ((v.exp != 0) && e >= int'(v.exp) + 1)) begin no++; if (fo < 0) fo = e; end
            if (gsr_hold != !((v.exp != 0) && e >= int'(v.exp) + 2)) begin ng++; if (fg < 0) fg = e; end
            if (init_pull_low != (v.crc[0] && v.err_at != 0 && e >= int'(v.err_at))) begin
                ni++; if (fi < 0) fi = e;
            end
        end
        frame_err = 1'b0;
        $display("vector %0d: expected done edge %0d", idx, v.exp);
        chk(nd == 0, "R4/R5 done edge (first bad edge as act)", fd, int'(v.exp));
        chk(no == 0, "R6 outs_active one edge after done (first bad edge)", fo, int'(v.exp) + 1);
        chk(ng == 0, "R6 gsr release two edges after done (first bad edge)", fg, int'(v.exp) + 2);
        chk(ni == 0, "R8/R9/R10 init_pull_low (first bad edge)", fi, int'(v.err_at));
    endtask

    bit wd_hit = 1'b0;
    initial begin
        #2000000;
        wd_hit = 1'b1;
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(done == 1'b0,          "R1 done after reset", done, 0);
        chk(outs_active == 1'b0,   "R1 outs_active after reset", outs_active, 0);
        chk(gsr_hold == 1'b1,      "R1 gsr_hold after reset", gsr_hold, 1);
        chk(init_pull_low == 1'b0, "R1 init_pull_low after reset", init_pull_low, 0);

        for (int i = 0; i < 8; i++) begin
            run_vec(VECS[i], i);
            if (i == 0) begin
                // R7: configured state ignores further activity
                int moved = 0;
                for (int j = 0; j < 12; j++) begin
                    mem_full = j[0]; len_vld = 1'b1; din = j[1];
                    crc_en = 1'b1; frame_err = 1'b1;
                    step();
                    if (!done || !outs_active || gsr_hold || init_pull_low) moved++;
                end
                chk(moved == 0, "R7 outputs held in configured state (edges moved)", moved, 0);
                frame_err = 1'b0; crc_en = 1'b0;
                // R1 reset from configured state
                prog_n = 1'b0;
                step();
                chk(!done && !outs_active && gsr_hold, "R1 reset clears startup",
                    {done, outs_active, gsr_hold}, 3'b001);
            end
            if (i == 6) begin
                // R8: error held until program/reset, then released
                step();
                chk(init_pull_low == 1'b1, "R8 error still held", init_pull_low, 1);
                prog_n = 1'b0;
                step();
                chk(init_pull_low == 1'b0, "R8 error cleared by reset", init_pull_low, 0);
            end
        end

        // R9: error on the very edge of the match blocks completion
        do_reset();
        crc_en = 1'b1;
        for (int e = 1; e <= 14; e++) begin
            len_vld = (e <= W); din = (e == 3);   // length 001000 = 8
            mem_full = 1'b1;
            frame_err = (e == 9);
            step();
        end
        frame_err = 1'b0;
        chk(done == 1'b0 && init_pull_low == 1'b1, "R9 error at match edge blocks done",
            {done, init_pull_low}, 2'b01);

        if (!wd_hit) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule